// File: doc/BRIEF.md
# ADS-B Preamble Hunter and Manchester-to-SPI Decoder

This block takes the single-bit digital output of a comparator that slices a 1 Mbit/s Mode-S reply. It oversamples that output eight times per bit and keeps searching for the 8 µs synchronisation preamble. The preamble is sixteen half-microsecond chips. When every chip matches, the block decodes the Manchester-coded data bits that follow, one per microsecond. It sends each decoded bit out as an SPI bus master. A host microcontroller, wired as an ordinary SPI slave, then receives whole frames and is only interrupted as bytes arrive.

The rf input first passes through a two-flop synchroniser. A sliding window holds the last sixteen chips' worth of samples. Each chip's level is taken by majority vote over its samples, and the sixteen levels are compared with the expected chip pattern. A control state machine has two states. `ST_HUNT` searches the window. On a match it takes the transition `hunt->decode` into `ST_DECODE`. There a bit slicer compares the ones in the first and second halves of each bit period. `ST_DECODE` goes back to `ST_HUNT` through `decode->hunt` on either of two events: the last bit of a full frame, or a bit with no mid-bit transition. The SPI side runs one bit period behind the slicer and generates its own clock at the bit rate.

Top module: `adsb_spi_decoder`

## Requirements
- R1: While `rst_n` is low and right after it is released, `spi_cs_n` is 1, `spi_sck` is 0 and `spi_mosi` is 0.
- R2: A frame starts only after sixteen consecutive chips of OSR/2 samples match the pattern 1010000101000000, where the leftmost chip is received first. If any chip is wrong, `spi_cs_n` stays 1 and no clock pulse appears.
- R3: A chip counts as high when more than half of its samples are 1. A single flipped sample inside one chip therefore does not stop detection.
- R4: A data bit whose first half is high and second half is low is a 1. Low then high is a 0. Bits leave on `spi_mosi` in the order they were received, first bit first (MSB first).
- R5: After FRAME_BITS bits have been delivered, `spi_cs_n` returns to 1 and any further data bits produce no clock pulse.
- R6: A data bit whose two halves are equal (no transition) ends the frame. The bits before it are delivered, and the bits after it are not.
- R7: `spi_sck` has a period of OSR clock cycles: low for the first half and high for the second. It pulses only while `spi_cs_n` is 0, and `spi_mosi` does not change at an `spi_sck` rising edge.
- R8: `spi_cs_n` falls once per frame and stays low without a break until the last bit's clock period ends.
- R9: After a frame ends, the block searches again, and a following preamble and frame are decoded the same way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, OSR times the data bit rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| rf_in | input | 1 | Asynchronous sliced receiver output |
| spi_mosi | output | 1 | Serial data to the host, first received bit first |
| spi_sck | output | 1 | Serial clock; the host samples on its rising edge |
| spi_cs_n | output | 1 | Slave select, active low, low for a frame's transfer |

## Verification
The bench builds the decoder with FRAME_BITS set to 24 and leaves OSR at 8 and the chip pattern at its default. The short frame length puts the full-length end of a frame, frames that carry surplus bits, and two frames sent back to back all within a few hundred microseconds of stimulus. The eightfold oversampling is kept, so the majority vote, the glitch tolerance and the half-period timing of the serial clock are exercised exactly as in a full-length build.

// File: rtl/adsb_dec_pkg.sv
package adsb_dec_pkg;

    localparam int PRE_CHIPS = 16;
    localparam logic [PRE_CHIPS-1:0] PRE_PATTERN = 16'b1010_0001_0100_0000;

    typedef enum logic [0:0] {
        ST_HUNT   = 1'b0,
        ST_DECODE = 1'b1
    } dec_state_e;

endpackage

// File: rtl/adsb_in_sync.sv
module adsb_in_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q  <= 1'b0;
            sync_out <= 1'b0;
        end else begin
            stage_q  <= async_in;
            sync_out <= stage_q;
        end
    end
endmodule

// File: rtl/adsb_preamble_det.sv
module adsb_preamble_det #(
    parameter int HALF  = 4,
    parameter int CHIPS = 16,
    parameter logic [CHIPS-1:0] PATTERN = 16'b1010_0001_0100_0000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic hit
);
    localparam int WIN = CHIPS * HALF;
    localparam int CW  = $clog2(HALF + 1);

    logic [WIN-1:0]   win_q;
    logic [CHIPS-1:0] level;

    // newest sample at bit 0; chip group g maps onto PATTERN[g]
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= {win_q[WIN-2:0], din};
    end

    for (genvar g = 0; g < CHIPS; g++) begin : g_vote
        logic [CW-1:0] ones;
        always_comb begin
            ones = '0;
            for (int s = 0; s < HALF; s++) begin
                ones = ones + CW'(win_q[g*HALF + s]);
            end
        end
        assign level[g] = (int'(ones) * 2) > HALF;
    end

    assign hit = (level == PATTERN);
endmodule

// File: rtl/adsb_bit_slicer.sv
module adsb_bit_slicer #(
    parameter int OSR = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic din,
    output logic strobe,
    output logic bit_val,
    output logic bad
);
    localparam int HALF = OSR / 2;
    localparam int PW   = $clog2(OSR);
    localparam int CW   = $clog2(HALF + 1);

    logic [PW-1:0] phase_q;
    logic [CW-1:0] cnt_a_q, cnt_b_q, cnt_b_tot;

    assign cnt_b_tot = cnt_b_q + CW'(din);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
            cnt_a_q <= '0;
            cnt_b_q <= '0;
            strobe  <= 1'b0;
            bit_val <= 1'b0;
            bad     <= 1'b0;
        end else begin
            strobe <= 1'b0;
            if (!en) begin
                phase_q <= '0;
                cnt_a_q <= '0;
                cnt_b_q <= '0;
            end else if (phase_q == PW'(OSR - 1)) begin
                strobe  <= 1'b1;
                bit_val <= cnt_a_q > cnt_b_tot;
                bad     <= cnt_a_q == cnt_b_tot;
                phase_q <= '0;
                cnt_a_q <= '0;
                cnt_b_q <= '0;
            end else begin
                phase_q <= phase_q + 1'b1;
                if (phase_q < PW'(HALF)) cnt_a_q <= cnt_a_q + CW'(din);
                else                     cnt_b_q <= cnt_b_tot;
            end
        end
    end
endmodule

// File: rtl/adsb_spi_tx.sv
module adsb_spi_tx #(
    parameter int OSR = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_valid,
    input  logic tx_bit,
    output logic mosi,
    output logic sck,
    output logic cs_n
);
    localparam int HALF = OSR / 2;
    localparam int PW   = $clog2(OSR);

    logic          busy_q;
    logic [PW-1:0] phase_q;
    logic          mosi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            phase_q <= '0;
            mosi_q  <= 1'b0;
        end else if (tx_valid) begin
            busy_q  <= 1'b1;
            phase_q <= '0;
            mosi_q  <= tx_bit;
        end else if (busy_q) begin
            if (phase_q == PW'(OSR - 1)) begin
                busy_q  <= 1'b0;
                phase_q <= '0;
                mosi_q  <= 1'b0;
            end else begin
                phase_q <= phase_q + 1'b1;
            end
        end
    end

    assign mosi = mosi_q;
    assign sck  = busy_q && (phase_q >= PW'(HALF));
    assign cs_n = !busy_q;
endmodule

// File: rtl/adsb_spi_decoder.sv
module adsb_spi_decoder
    import adsb_dec_pkg::*;
#(
    parameter int OSR        = 8,
    parameter int FRAME_BITS = 112,
    parameter logic [PRE_CHIPS-1:0] PREAMBLE = PRE_PATTERN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rf_in,
    output logic spi_mosi,
    output logic spi_sck,
    output logic spi_cs_n
);
    localparam int HALF  = OSR / 2;
    localparam int CNT_W = $clog2(FRAME_BITS + 1);

    dec_state_e       state, state_nx;
    logic [CNT_W-1:0] bit_cnt;
    logic             rf_sync, pre_hit;
    logic             slc_strobe, slc_bit, slc_bad;
    logic             tx_valid;

    adsb_in_sync sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (rf_in),
        .sync_out (rf_sync)
    );

    adsb_preamble_det #(
        .HALF    (HALF),
        .CHIPS   (PRE_CHIPS),
        .PATTERN (PREAMBLE)
    ) pre_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rf_sync),
        .hit   (pre_hit)
    );

    adsb_bit_slicer #(.OSR(OSR)) slc_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (state == ST_DECODE),
        .din     (rf_sync),
        .strobe  (slc_strobe),
        .bit_val (slc_bit),
        .bad     (slc_bad)
    );

    assign tx_valid = (state == ST_DECODE) && slc_strobe && !slc_bad;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= state_nx;
    end

    // transitions: hunt->decode on preamble, decode->hunt on bad bit or full frame
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HUNT:   if (pre_hit) state_nx = ST_DECODE;
            ST_DECODE: if (slc_strobe && (slc_bad || bit_cnt == CNT_W'(FRAME_BITS - 1)))
                           state_nx = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   bit_cnt <= '0;
        else if (state_nx == ST_HUNT) bit_cnt <= '0;
        else if (tx_valid)            bit_cnt <= bit_cnt + 1'b1;
    end

    // outputs
    adsb_spi_tx #(.OSR(OSR)) tx_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_valid (tx_valid),
        .tx_bit   (slc_bit),
        .mosi     (spi_mosi),
        .sck      (spi_sck),
        .cs_n     (spi_cs_n)
    );
endmodule

// File: rtl/adsb_spi_decoder_chk.sv
module adsb_spi_decoder_chk
    import adsb_dec_pkg::*;
#(
    parameter int FRAME_BITS = 112,
    parameter int CNT_W      = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             spi_mosi,
    input logic             spi_sck,
    input logic             spi_cs_n,
    input dec_state_e       state,
    input logic [CNT_W-1:0] bit_cnt,
    input logic             tx_valid,
    input logic             slc_strobe,
    input logic             slc_bad
);
    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (spi_cs_n && !spi_sck && !spi_mosi)); // R1

    AST_SCK_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck); // R7

    AST_MOSI_STABLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_sck) |-> $stable(spi_mosi)); // R7

    AST_SCK_HIGH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_sck) |=> spi_sck); // R7

    AST_SELECT_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> !spi_sck); // R8

    AST_BAD_BIT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DECODE && slc_strobe && slc_bad) |=> (state == ST_HUNT)); // R6

    AST_FULL_FRAME_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && bit_cnt == CNT_W'(FRAME_BITS - 1)) |=> (state == ST_HUNT && !spi_cs_n)); // R5

    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt < CNT_W'(FRAME_BITS)); // R5
endmodule

bind adsb_spi_decoder adsb_spi_decoder_chk #(
    .FRAME_BITS (FRAME_BITS),
    .CNT_W      (CNT_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .spi_mosi   (spi_mosi),
    .spi_sck    (spi_sck),
    .spi_cs_n   (spi_cs_n),
    .state      (state),
    .bit_cnt    (bit_cnt),
    .tx_valid   (tx_valid),
    .slc_strobe (slc_strobe),
    .slc_bad    (slc_bad)
);

// File: tb/adsb_spi_decoder_tb.sv
module adsb_spi_decoder_tb_top;
    localparam int OSR    = 8;
    localparam int NBITS  = 24;
    localparam logic [15:0] PRE_OK = 16'b1010_0001_0100_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rf_in = 1'b0;
    logic spi_mosi, spi_sck, spi_cs_n;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    adsb_spi_decoder #(.OSR(OSR), .FRAME_BITS(NBITS)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rf_in    (rf_in),
        .spi_mosi (spi_mosi),
        .spi_sck  (spi_sck),
        .spi_cs_n (spi_cs_n)
    );

    // port monitor, sampled on the falling clock edge
    logic cap [0:127];
    int   cap_n = 0, frames = 0, per_err = 0, idle_err = 0, stab_err = 0;
    int   cyc = 0, last_rise = -1;
    logic sck_prev = 1'b0, cs_prev = 1'b1, mosi_prev = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (spi_cs_n && spi_sck) idle_err++;
        if (!spi_cs_n && cs_prev) frames++;
        if (spi_cs_n) last_rise = -1;
        if (!spi_cs_n && spi_sck && !sck_prev) begin
            if (cap_n < 128) cap[cap_n] = spi_mosi;
            cap_n++;
            if (spi_mosi !== mosi_prev) stab_err++;
            if (last_rise >= 0 && cyc - last_rise != OSR) per_err++;
            last_rise = cyc;
        end
        sck_prev  = spi_sck;
        cs_prev   = spi_cs_n;
        mosi_prev = spi_mosi;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        cap_n = 0; frames = 0; per_err = 0; idle_err = 0; stab_err = 0;
    endtask

    task automatic drive(input logic v);
        @(negedge clk);
        rf_in = v;
    endtask

    // stop_at: index of a bit sent without transition; glitch: preamble sample to flip
    task automatic send_frame(input logic [15:0] pre, input logic [127:0] data,
                              input int nbits, input int stop_at, input int glitch);
        for (int i = 0; i < 20; i++) drive(1'b0);
        for (int c = 0; c < 16; c++)
            for (int s = 0; s < OSR/2; s++)
                drive(pre[15-c] ^ ((c*(OSR/2) + s) == glitch));
        for (int b = 0; b < nbits; b++) begin
            logic d;
            d = data[nbits-1-b];
            for (int s = 0; s < OSR; s++)
                drive((b == stop_at) ? 1'b1 : ((s < OSR/2) ? d : !d));
        end
        for (int i = 0; i < 60; i++) drive(1'b0);
    endtask

    function automatic int bit_mismatch(input logic [127:0] data, input int nbits,
                                        input int n, input int offset);
        for (int i = 0; i < n; i++)
            if (cap[offset + i] !== data[nbits-1-i]) return i;
        return -1;
    endfunction

    task automatic t_reset();
        chk(spi_cs_n === 1'b1, "R1 cs_n in reset", int'(spi_cs_n), 1);
        chk(spi_sck  === 1'b0, "R1 sck in reset", int'(spi_sck), 0);
        chk(spi_mosi === 1'b0, "R1 mosi in reset", int'(spi_mosi), 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(spi_cs_n === 1'b1 && spi_sck === 1'b0, "R1 idle after release",
            int'({spi_cs_n, spi_sck}), 2);
    endtask

    task automatic t_frame(input logic [127:0] data, input string tag);
        int mm;
        clear_mon();
        send_frame(PRE_OK, data, NBITS, -1, -1);
        mm = bit_mismatch(data, NBITS, NBITS, 0);
        chk(cap_n == NBITS, {tag, " R5 bit count"}, cap_n, NBITS);
        chk(mm < 0, {tag, " R4 bit values MSB first"}, mm, -1);
        chk(frames == 1, {tag, " R8 one select period"}, frames, 1);
        chk(per_err == 0, {tag, " R7 sck period"}, per_err, 0);
        chk(stab_err == 0 && idle_err == 0, {tag, " R7 mosi stable, sck idle"},
            stab_err + idle_err, 0);
    endtask

    task automatic t_bad_preamble();
        clear_mon();
        send_frame(16'b1011_0001_0100_0000, 128'hA5F00F, NBITS, -1, -1);
        chk(frames == 0 && cap_n == 0, "R2 wrong chip rejected", frames + cap_n, 0);
        clear_mon();
        send_frame(16'b1010_0001_0100_0001, 128'h5A5A5A, NBITS, -1, -1);
        chk(frames == 0 && cap_n == 0, "R2 wrong last chip rejected", frames + cap_n, 0);
    endtask

    task automatic t_glitch();
        int mm;
        clear_mon();
        send_frame(PRE_OK, 128'h3C96E1, NBITS, -1, 13);
        mm = bit_mismatch(128'h3C96E1, NBITS, NBITS, 0);
        chk(cap_n == NBITS && mm < 0, "R3 glitch in low chip tolerated", cap_n, NBITS);
        clear_mon();
        send_frame(PRE_OK, 128'h81C3E7, NBITS, -1, 1);
        chk(cap_n == NBITS, "R3 glitch in high chip tolerated", cap_n, NBITS);
    endtask

    task automatic t_early_end();
        int mm;
        clear_mon();
        send_frame(PRE_OK, 128'hB2D4F6, NBITS, 10, -1);
        mm = bit_mismatch(128'hB2D4F6, NBITS, 10, 0);
        chk(cap_n == 10, "R6 bits before missing transition", cap_n, 10);
        chk(mm < 0, "R6 delivered bit values", mm, -1);
        chk(frames == 1 && spi_cs_n === 1'b1, "R6 select released", frames, 1);
    endtask

    task automatic t_surplus();
        int mm;
        clear_mon();
        send_frame(PRE_OK, 128'h2AB_CDEF12, 36, -1, -1);
        mm = bit_mismatch(128'h2AB_CDEF12, 36, NBITS, 0);
        chk(cap_n == NBITS, "R5 surplus bits ignored", cap_n, NBITS);
        chk(mm < 0, "R5 first bits delivered", mm, -1);
    endtask

    task automatic t_back_to_back();
        int mm1, mm2;
        clear_mon();
        send_frame(PRE_OK, 128'hC0FFEE, NBITS, -1, -1);
        send_frame(PRE_OK, 128'h13579B, NBITS, -1, -1);
        mm1 = bit_mismatch(128'hC0FFEE, NBITS, NBITS, 0);
        mm2 = bit_mismatch(128'h13579B, NBITS, NBITS, NBITS);
        chk(frames == 2 && cap_n == 2*NBITS, "R9 second frame decoded", cap_n, 2*NBITS);
        chk(mm1 < 0 && mm2 < 0, "R9 both frames' bits", mm1 + mm2, -2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        t_frame(128'hA5C31E, "pattern mixed");
        t_frame(128'hFFFFFF, "all ones");
        t_frame(128'h000000, "all zeros");
        t_frame(128'h555555, "alternating");
        t_bad_preamble();
        t_glitch();
        t_early_end();
        t_surplus();
        t_back_to_back();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule